// File: doc/BRIEF.md
# Run-Length Multi-Level Line Encoder

This block is the transmit half of a three-wire serial link. It takes a serial stream of bits, one per handshake, and folds each stretch of equal bits into a single symbol. Each symbol is one transition on the `line_clk` wire plus a digital repeat count on `run_count`. An upward transition carries ones and a downward transition carries zeros, so the wire's level after the transition is the data value. The count is meant to drive an external level generator and is not analog here. Because the wire moves only at run boundaries and at split points, the far end can clock its receiver directly from it.

A run longer than `MAX_COUNT` is cut into full chunks followed by a remainder. Between two chunks of the same value the encoder flips `line_clk` the other way with a count of zero, which the receiver treats as "no data". It then flips back with the next chunk's count. Every symbol, including zero-count ones, is held for `HOLD_CYCLES` clock cycles so the receiver's converter can settle. Input is stalled for the whole hold. A packet opens with a zero-count lead symbol that puts the wire at the inverse of the first bit, so the first run gets the right transition direction. A bit flagged as last flushes the open run. `busy` stays high until that final symbol has finished its hold.

The controller has five states:
- `ST_IDLE`: no packet.
- `ST_LEAD`: lead symbol hold.
- `ST_COLLECT`: counting equal bits.
- `ST_RUN`: data symbol hold.
- `ST_ZERO`: split symbol hold.

Its transitions are:
- start: `ST_IDLE`→`ST_LEAD`, on the first bit.
- lead-done: `ST_LEAD`→`ST_COLLECT`, or →`ST_RUN` when the first bit was also last.
- emit: `ST_COLLECT`→`ST_RUN`, on a differing bit, on a bit arriving with the run full, or on a last bit.
- split: `ST_RUN`→`ST_ZERO`.
- resume: `ST_RUN`/`ST_ZERO`→`ST_COLLECT`.
- flush: `ST_RUN`/`ST_ZERO`→`ST_RUN`, for a pending final run.
- done: `ST_RUN`→`ST_IDLE`.

Top module: `rle_line_encoder`

## Requirements
- R1: After reset `line_clk`=0, `run_count`=0, `busy`=0 and `bit_ready`=1. `bit_ready` is 1 whenever the block is idle or collecting, and a bit is taken on a rising clock edge with `bit_valid`=1 and `bit_ready`=1.
- R2: A run of n equal bits of value v (n ≤ `MAX_COUNT`) is sent as one symbol: `line_clk` changes to v and `run_count` becomes n on the same clock edge. A nonzero count never appears without a `line_clk` change.
- R3: `run_count` never exceeds `MAX_COUNT`. A run of n > `MAX_COUNT` is sent as chunks of `MAX_COUNT` followed by the remainder.
- R4: Between two chunks of one run, `line_clk` changes to the inverse value with `run_count`=0, then changes back with the next chunk's count.
- R5: While busy, every value of (`line_clk`, `run_count`) stays on the outputs for at least `HOLD_CYCLES` cycles.
- R6: On a packet's first bit b, `line_clk` is set to not-b with `run_count`=0. This gives a transition only when the wire was not already at that level.
- R7: A bit with `bit_last`=1 flushes the open run. This also holds when that bit differs from the run, in which case it becomes its own final symbol of count 1. `busy` falls exactly `HOLD_CYCLES` cycles after the final symbol appears. From then on `run_count`=0 and `line_clk` keeps the final data value.
- R8: `bit_ready` is 0 during the hold of every symbol: lead, data and zero-count.
- R9: A run of exactly `MAX_COUNT` bits followed by a differing bit produces no zero-count symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | A bit is offered on `bit_data` |
| bit_data | input | 1 | Offered data bit |
| bit_last | input | 1 | Offered bit closes the packet |
| bit_ready | output | 1 | Encoder can take a bit this cycle |
| line_clk | output | 1 | Registered data/clock wire level |
| run_count | output | $clog2(MAX_COUNT+1) | Repeat count for the current symbol, 0 for lead and split symbols |
| busy | output | 1 | Packet in progress, including the final hold |

## Verification
Two functions can fall in the same cycle: the last-bit flush and the chunk split. With `MAX_COUNT`=5, a packet of eleven ones makes the closing bit arrive exactly when the run is full. That one bit must then start a zero-count split and also mark the remainder as final. The outcome is judged by the transition list 5,0,5,0,1 and by `busy` falling one hold after the last count-1 symbol. A second overlap, a differing last bit that closes one run and is itself a final run, is provoked by a packet ending in a single flipped bit and judged the same way.

// File: rtl/rle_enc_pkg.sv
package rle_enc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_COLLECT,
        ST_RUN,
        ST_ZERO
    } enc_state_e;

endpackage

// File: rtl/rle_hold_timer.sv
module rle_hold_timer #(
    parameter int HOLD_CYCLES = 3,
    localparam int TW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= TW'(HOLD_CYCLES - 1);
        end else if (left_q != '0) begin
            left_q <= left_q - TW'(1);
        end
    end

    assign done = (left_q == '0);

endmodule

// File: rtl/rle_run_reg.sv
module rle_run_reg #(
    parameter int MAX_COUNT = 5,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_val,
    input  logic          inc,
    output logic          val,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= 1'b0;
            cnt <= '0;
        end else if (load) begin
            val <= load_val;
            cnt <= CW'(1);
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/rle_line_encoder.sv
module rle_line_encoder
    import rle_enc_pkg::*;
#(
    parameter int MAX_COUNT   = 5,
    parameter int HOLD_CYCLES = 3,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_valid,
    input  logic          bit_data,
    input  logic          bit_last,
    output logic          bit_ready,
    output logic          line_clk,
    output logic [CW-1:0] run_count,
    output logic          busy
);

    enc_state_e    state_q, state_d;
    logic          run_val;
    logic [CW-1:0] run_cnt;
    logic          run_load, run_inc;
    logic          hold_done;
    logic          sym_load, sym_line;
    logic [CW-1:0] sym_cnt;
    logic          split_q, split_d;
    logic          fin_q, fin_d;
    logic          final_q, final_d;
    logic          take;

    rle_run_reg #(.MAX_COUNT(MAX_COUNT)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (run_load),
        .load_val (bit_data),
        .inc      (run_inc),
        .val      (run_val),
        .cnt      (run_cnt)
    );

    rle_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sym_load),
        .done  (hold_done)
    );

    assign bit_ready = (state_q == ST_IDLE) || (state_q == ST_COLLECT);
    assign busy      = (state_q != ST_IDLE);
    assign take      = bit_valid && bit_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and symbol control
    always_comb begin
        state_d  = state_q;
        sym_load = 1'b0;
        sym_line = line_clk;
        sym_cnt  = '0;
        run_load = 1'b0;
        run_inc  = 1'b0;
        split_d  = split_q;
        fin_d    = fin_q;
        final_d  = final_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    sym_load = 1'b1;
                    sym_line = ~bit_data;
                    run_load = 1'b1;
                    fin_d    = bit_last;
                    split_d  = 1'b0;
                    final_d  = 1'b0;
                    state_d  = ST_LEAD;
                end
            end
            ST_COLLECT: begin
                if (take) begin
                    if (bit_data != run_val) begin
                        sym_load = 1'b1;
                        sym_line = run_val;
                        sym_cnt  = run_cnt;
                        run_load = 1'b1;
                        fin_d    = bit_last;
                        state_d  = ST_RUN;
                    end else if (run_cnt == CW'(MAX_COUNT)) begin
                        sym_load = 1'b1;
                        sym_line = run_val;
                        sym_cnt  = run_cnt;
                        run_load = 1'b1;
                        split_d  = 1'b1;
                        fin_d    = bit_last;
                        state_d  = ST_RUN;
                    end else if (bit_last) begin
                        sym_load = 1'b1;
                        sym_line = run_val;
                        sym_cnt  = run_cnt + CW'(1);
                        final_d  = 1'b1;
                        state_d  = ST_RUN;
                    end else begin
                        run_inc = 1'b1;
                    end
                end
            end
            ST_LEAD, ST_ZERO: begin
                if (hold_done) begin
                    if (fin_q) begin
                        sym_load = 1'b1;
                        sym_line = run_val;
                        sym_cnt  = run_cnt;
                        fin_d    = 1'b0;
                        final_d  = 1'b1;
                        state_d  = ST_RUN;
                    end else begin
                        state_d = ST_COLLECT;
                    end
                end
            end
            ST_RUN: begin
                if (hold_done) begin
                    if (split_q) begin
                        sym_load = 1'b1;
                        sym_line = ~run_val;
                        split_d  = 1'b0;
                        state_d  = ST_ZERO;
                    end else if (final_q) begin
                        sym_load = 1'b1;
                        final_d  = 1'b0;
                        state_d  = ST_IDLE;
                    end else if (fin_q) begin
                        sym_load = 1'b1;
                        sym_line = run_val;
                        sym_cnt  = run_cnt;
                        fin_d    = 1'b0;
                        final_d  = 1'b1;
                    end else begin
                        state_d = ST_COLLECT;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs and sequencing flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_clk  <= 1'b0;
            run_count <= '0;
            split_q   <= 1'b0;
            fin_q     <= 1'b0;
            final_q   <= 1'b0;
        end else begin
            if (sym_load) begin
                line_clk  <= sym_line;
                run_count <= sym_cnt;
            end
            split_q <= split_d;
            fin_q   <= fin_d;
            final_q <= final_d;
        end
    end

endmodule

// File: rtl/rle_line_encoder_chk.sv
module rle_line_encoder_chk #(
    parameter int MAX_COUNT   = 5,
    parameter int HOLD_CYCLES = 3,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_ready,
    input logic          line_clk,
    input logic [CW-1:0] run_count,
    input logic          busy
);

    logic          prev_line, prev_busy;
    logic [CW-1:0] prev_cnt;
    int unsigned   age;
    logic          chg;

    assign chg = (line_clk != prev_line) || (run_count != prev_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_line <= 1'b0;
            prev_cnt  <= '0;
            prev_busy <= 1'b0;
            age       <= HOLD_CYCLES;
        end else begin
            prev_line <= line_clk;
            prev_cnt  <= run_count;
            prev_busy <= busy;
            if (chg) age <= 1;
            else if (age < HOLD_CYCLES) age <= age + 1;
        end
    end

    // R5
    hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && prev_busy) |-> (age >= HOLD_CYCLES));

    // R3
    max_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_count <= CW'(MAX_COUNT));

    // R2
    edge_with_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_count != prev_cnt && run_count != '0) |-> (line_clk != prev_line));

    // R8
    edge_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_clk != prev_line) |-> !bit_ready);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (run_count == '0));

    // R1
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> bit_ready);

endmodule

bind rle_line_encoder rle_line_encoder_chk #(
    .MAX_COUNT   (MAX_COUNT),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_ready (bit_ready),
    .line_clk  (line_clk),
    .run_count (run_count),
    .busy      (busy)
);

// File: tb/sim_rle_line_encoder.sv
module sim_rle_line_encoder;

    localparam int MAXC = 5;
    localparam int HOLD = 3;
    localparam int CW   = $clog2(MAXC + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_valid = 1'b0, bit_data = 1'b0, bit_last = 1'b0;
    logic          bit_ready, line_clk, busy;
    logic [CW-1:0] run_count;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    rle_line_encoder #(.MAX_COUNT(MAXC), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
        .bit_last(bit_last), .bit_ready(bit_ready), .line_clk(line_clk),
        .run_count(run_count), .busy(busy)
    );

    // monitor: transitions seen at the falling edge
    int   cyc = 0, n_edges = 0, fall_cyc = 0, last_edge = -1000, stall_bad = 0;
    logic e_line [64];
    int   e_cnt  [64];
    int   e_cyc  [64];
    logic prev_line_s = 1'b0, prev_busy_s = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (line_clk != prev_line_s) begin
                if (n_edges < 64) begin
                    e_line[n_edges] = line_clk;
                    e_cnt[n_edges]  = int'(run_count);
                    e_cyc[n_edges]  = cyc;
                end
                n_edges   = n_edges + 1;
                last_edge = cyc;
            end
            if ((cyc - last_edge) < HOLD && bit_ready) stall_bad = stall_bad + 1;
            if (prev_busy_s && !busy) fall_cyc = cyc;
        end
        prev_line_s = line_clk;
        prev_busy_s = busy;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(input string s, input int gap);
        for (int i = 0; i < s.len(); i++) begin
            bit_valid = 1'b1;
            bit_data  = (s[i] == "1");
            bit_last  = (i == s.len() - 1);
            while (!bit_ready) @(negedge clk);
            @(negedge clk);
            bit_valid = 1'b0;
            bit_last  = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    logic model_line = 1'b0;

    task automatic run_case(input string tag, input string bits, input int gap);
        logic x_line [64];
        int   x_cnt  [64];
        int   nx = 0;
        int   i = 0;
        int   t = 0;
        int   maxseen = 0;
        logic first;
        first = (bits[0] == "1");
        if (model_line != ~first) begin
            x_line[nx] = ~first; x_cnt[nx] = 0; nx++;
        end
        while (i < bits.len()) begin
            logic v;
            int   r = 0;
            int   c;
            v = (bits[i] == "1");
            while (i < bits.len() && ((bits[i] == "1") == v)) begin
                r++; i++;
            end
            c = (r > MAXC) ? MAXC : r;
            x_line[nx] = v; x_cnt[nx] = c; nx++; r -= c;
            while (r > 0) begin
                c = (r > MAXC) ? MAXC : r;
                x_line[nx] = ~v; x_cnt[nx] = 0; nx++;
                x_line[nx] = v;  x_cnt[nx] = c; nx++;
                r -= c;
            end
        end
        n_edges   = 0;
        stall_bad = 0;
        send(bits, gap);
        while (busy && t < 3000) begin
            @(negedge clk); t++;
        end
        @(negedge clk);
        #1;
        chk(n_edges == nx, tag, {bits, " transition count"}, n_edges, nx);
        for (int k = 0; k < nx && k < n_edges; k++) begin
            chk(e_line[k] == x_line[k], tag, $sformatf("%s edge %0d level", bits, k),
                int'(e_line[k]), int'(x_line[k]));
            chk(e_cnt[k] == x_cnt[k], tag, $sformatf("%s edge %0d count", bits, k),
                e_cnt[k], x_cnt[k]);
            if (e_cnt[k] > maxseen) maxseen = e_cnt[k];
            if (k > 0)
                chk((e_cyc[k] - e_cyc[k-1]) >= HOLD, "R5",
                    $sformatf("%s gap before edge %0d", bits, k),
                    e_cyc[k] - e_cyc[k-1], HOLD);
        end
        chk(maxseen <= MAXC, "R3", {bits, " largest count"}, maxseen, MAXC);
        chk(stall_bad == 0, "R8", {bits, " ready during hold"}, stall_bad, 0);
        chk(busy == 1'b0, "R7", {bits, " busy after packet"}, int'(busy), 0);
        chk(run_count == '0, "R7", {bits, " idle count"}, int'(run_count), 0);
        chk(line_clk == (bits[bits.len()-1] == "1"), "R7", {bits, " final level"},
            int'(line_clk), int'(bits[bits.len()-1] == "1"));
        if (n_edges > 0 && n_edges <= 64)
            chk((fall_cyc - e_cyc[n_edges-1]) == HOLD, "R7", {bits, " busy fall delay"},
                fall_cyc - e_cyc[n_edges-1], HOLD);
        chk(bit_ready == 1'b1, "R1", {bits, " ready when idle"}, int'(bit_ready), 1);
        model_line = (bits[bits.len()-1] == "1");
    endtask

    task automatic test_reset();
        #1;
        chk(line_clk == 1'b0, "R1", "reset line level", int'(line_clk), 0);
        chk(run_count == '0, "R1", "reset count", int'(run_count), 0);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(bit_ready == 1'b1, "R1", "reset ready", int'(bit_ready), 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_case("R2", "111110000111001", 0);   // mixed runs, no lead transition
        run_case("R6", "1000", 0);              // lead transition to 0 first
        run_case("R9", "1111100000", 0);        // exact maximum, then switch
        run_case("R4", "11111111111", 0);       // split with flush on full run
        run_case("R7", "00111110", 0);          // differing last bit
        run_case("R2", "10101", 2);             // alternating with input gaps
        run_case("R3", "0000000000000", 1);     // two splits, gaps
        run_case("R6", "0", 0);                 // single bit packet
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule